// File: doc/BRIEF.md
# Dual-Channel Prescaled PWM Timer with Staged Register Updates

This block generates two pulse-width modulated outputs. It is configured through a simple 32-bit register port with separate write and read strobes. Each channel has four software-visible registers: control, clock divider, cycle length and high time. A channel counts input clocks through a divider, then counts divided ticks up to the cycle length. Its output is in the active state while the tick count is below the high-time value.

Software writes land in a staging copy of each register. They reach the running counter logic only when the transfer condition for that register is met. A shared status word holds one flag per staged register. A flag is set when its register is written and clears when the value has been moved into the working copy, so firmware can poll it before it relies on a change. Transfers can be deferred to the end of the running cycle, which gives glitch-free reprogramming. They can also be forced at once through control bits. Stopping a channel either lets the cycle finish or cuts it off.

Top module: `dpwm_top`

## Requirements
- R1: After reset, both outputs are 0, and reads of the status word and of every implemented register return 0.
- R2: Channel n (n = 0, 1) has its registers at byte address 0x10·n plus 0x0 for control, 0x4 for the divider, 0x8 for the cycle length and 0xC for the high time; address bits [1:0] are ignored. Read data appears on rdata_o in the cycle after the read strobe. A read returns the last written value cut to the field width: control 6 bits, divider 10 bits, cycle length 12 bits, high time 12 bits.
- R3: The status word at 0x40 holds channel n's flags at bits 8·n+0 (control), 8·n+1 (divider), 8·n+2 (cycle length) and 8·n+3 (high time). A flag is set by a write to its register and reads 1 until that value is transferred.
- R4: A control write always transfers on the clock edge after the write, and its flag clears there.
- R5: Control bit 0 enables the channel. The first cycle starts two clocks after the enabling write. One cycle lasts (divider+1)·(length+1) clocks. During divided tick k of a cycle (k = 0..length) the output is active when k < high time. A high time above the length gives a constant active output, and a high time of 0 gives a constant inactive output.
- R6: Control bit 1 inverts the output level. The inactive level, which is also the level of a stopped channel, is 1 when inversion is set.
- R7: With control bit 2 (deferred load) set on a running channel, staged divider, length and high-time values transfer on the last clock of the current cycle, and their flags stay set until then.
- R8: With bit 2 clear on a running channel, a staged high time transfers on the next clock. A staged divider transfers only while control bit 4 is set, and a staged length only while control bit 5 is set.
- R9: On a stopped channel, staged divider, length and high-time values transfer on the next clock.
- R10: Clearing bit 0 with bit 3 clear lets the current cycle run to its end, after which the output stays inactive.
- R11: Clearing bit 0 with bit 3 (stop now) set makes the output inactive from the second clock after the write.
- R12: Addresses 0x20 to 0x3F, 0x44 to 0x4F and 0x50 to 0x7F read as 0. Writes to them, and writes to 0x40, change no register and no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for registers and counters |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| rd_en_i | input | 1 | Read strobe, data valid the next cycle |
| addr_i | input | ADDR_W (7) | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| pwm_o | output | NUM_CH (2) | PWM outputs, bit n for channel n |

## Verification
The hardest state to reach is a staged write that sits pending on a running channel. The bench only knows the cycle phase because it starts the channel at a known clock. From that phase it places a high-time write in the middle of a cycle under deferred load, then samples every clock across the boundary: the old waveform must hold up to the boundary and the new one must start right after it. The stop tests inject the control write from inside the sampling loop, at a fixed phase, so that finishing the cycle and cutting it off give different samples. The length and divider writes under immediate mode are left pending for several cycles before the matching load bit releases them.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
  localparam int NREG         = 4;
  localparam int STAT_GROUP_W = 8;
  localparam int BUS_W        = 32;

  typedef enum logic [1:0] {
    SEL_CTL  = 2'd0,
    SEL_PRE  = 2'd1,
    SEL_PER  = 2'd2,
    SEL_DUTY = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic load_per;
    logic load_pre;
    logic stop_now;
    logic autoload;
    logic invert;
    logic enable;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);
endpackage

// File: rtl/dpwm_core.sv
module dpwm_core #(
  parameter int PRE_W = 10,
  parameter int PER_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             stop_now_i,
  input  logic             invert_i,
  input  logic [PRE_W-1:0] pre_i,
  input  logic [PER_W-1:0] per_i,
  input  logic [PER_W-1:0] duty_i,
  output logic             running_o,
  output logic             boundary_o,
  output logic             pwm_o
);
  logic             running_q;
  logic [PRE_W-1:0] pre_cnt_q;
  logic [PER_W-1:0] cnt_q;
  logic             pre_wrap, cnt_wrap;

  // >= so that a shrunk limit never lets a counter run past it
  assign pre_wrap = pre_cnt_q >= pre_i;
  assign cnt_wrap = cnt_q >= per_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      running_q <= 1'b0;
      pre_cnt_q <= '0;
      cnt_q     <= '0;
    end else if (!running_q) begin
      pre_cnt_q <= '0;
      cnt_q     <= '0;
      running_q <= enable_i;
    end else if (!enable_i && stop_now_i) begin
      running_q <= 1'b0;
      pre_cnt_q <= '0;
      cnt_q     <= '0;
    end else if (!pre_wrap) begin
      pre_cnt_q <= pre_cnt_q + 1'b1;
    end else begin
      pre_cnt_q <= '0;
      if (!cnt_wrap) begin
        cnt_q <= cnt_q + 1'b1;
      end else begin
        cnt_q     <= '0;
        running_q <= enable_i;
      end
    end
  end

  assign running_o  = running_q;
  assign boundary_o = running_q & pre_wrap & cnt_wrap;
  assign pwm_o      = (running_q & (cnt_q < duty_i)) ^ invert_i;

  a_r11_stop_now: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running_q && !enable_i && stop_now_i |=> !running_q);

  a_r10_drain_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running_q && !enable_i && !stop_now_i && !boundary_o |=> running_q);

  a_r5_idle_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !running_q |-> (cnt_q == '0 && pre_cnt_q == '0));
endmodule

// File: rtl/dpwm_chan.sv
module dpwm_chan
  import dpwm_pkg::*;
#(
  parameter int PRE_W = 10,
  parameter int PER_W = 12
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NREG-1:0]            wr_sel_i,
  input  logic [BUS_W-1:0]           wdata_i,
  output logic [NREG-1:0][BUS_W-1:0] words_o,
  output logic [NREG-1:0]            pend_o,
  output logic                       pwm_o
);
  ctl_t             ctl_sh_q, ctl_act_q;
  logic [PRE_W-1:0] pre_sh_q, pre_act_q;
  logic [PER_W-1:0] per_sh_q, per_act_q;
  logic [PER_W-1:0] duty_sh_q, duty_act_q;
  logic [NREG-1:0]  pend_q, go;
  logic             running, boundary, xfer_all;
  logic             unused_wdata;

  assign unused_wdata = ^wdata_i;
  assign xfer_all = !running | (ctl_act_q.autoload & boundary);

  always_comb begin
    go           = '0;
    go[SEL_CTL]  = 1'b1;
    go[SEL_PRE]  = xfer_all | (!ctl_act_q.autoload & ctl_act_q.load_pre);
    go[SEL_PER]  = xfer_all | (!ctl_act_q.autoload & ctl_act_q.load_per);
    go[SEL_DUTY] = xfer_all | !ctl_act_q.autoload;
    // a write in the same cycle wins and keeps the flag set
    go           = go & pend_q & ~wr_sel_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_sh_q   <= '0;
      pre_sh_q   <= '0;
      per_sh_q   <= '0;
      duty_sh_q  <= '0;
      ctl_act_q  <= '0;
      pre_act_q  <= '0;
      per_act_q  <= '0;
      duty_act_q <= '0;
      pend_q     <= '0;
    end else begin
      if (wr_sel_i[SEL_CTL])  ctl_sh_q  <= ctl_t'(wdata_i[CTL_W-1:0]);
      if (wr_sel_i[SEL_PRE])  pre_sh_q  <= wdata_i[PRE_W-1:0];
      if (wr_sel_i[SEL_PER])  per_sh_q  <= wdata_i[PER_W-1:0];
      if (wr_sel_i[SEL_DUTY]) duty_sh_q <= wdata_i[PER_W-1:0];
      if (go[SEL_CTL])  ctl_act_q  <= ctl_sh_q;
      if (go[SEL_PRE])  pre_act_q  <= pre_sh_q;
      if (go[SEL_PER])  per_act_q  <= per_sh_q;
      if (go[SEL_DUTY]) duty_act_q <= duty_sh_q;
      pend_q <= (pend_q & ~go) | wr_sel_i;
    end
  end

  dpwm_core #(.PRE_W(PRE_W), .PER_W(PER_W)) i_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .enable_i   (ctl_act_q.enable),
    .stop_now_i (ctl_act_q.stop_now),
    .invert_i   (ctl_act_q.invert),
    .pre_i      (pre_act_q),
    .per_i      (per_act_q),
    .duty_i     (duty_act_q),
    .running_o  (running),
    .boundary_o (boundary),
    .pwm_o      (pwm_o)
  );

  always_comb begin
    words_o           = '0;
    words_o[SEL_CTL]  = BUS_W'(ctl_sh_q);
    words_o[SEL_PRE]  = BUS_W'(pre_sh_q);
    words_o[SEL_PER]  = BUS_W'(per_sh_q);
    words_o[SEL_DUTY] = BUS_W'(duty_sh_q);
  end
  assign pend_o = pend_q;

  a_r2_sel_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_sel_i));

  a_r3_flag_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_sel_i != '0) |=> ((pend_q & $past(wr_sel_i)) == $past(wr_sel_i)));

  a_r4_ctl_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q[SEL_CTL] && !wr_sel_i[SEL_CTL] |=> !pend_q[SEL_CTL]);

  a_r7_hold_duty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running && ctl_act_q.autoload && !boundary |=> $stable(duty_act_q));

  a_r8_pre_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running && !ctl_act_q.autoload && !ctl_act_q.load_pre |=> $stable(pre_act_q));
endmodule

// File: rtl/dpwm_top.sv
module dpwm_top
  import dpwm_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int PRE_W  = 10,
  parameter int PER_W  = 12,
  parameter int ADDR_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  output logic [NUM_CH-1:0] pwm_o
);
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(7'h40);

  logic [1:0]       slot, reg_idx;
  logic             in_chan, is_stat, unused_lsb;
  logic [BUS_W-1:0] rd_word, rdata_q;
  logic [NUM_CH-1:0][NREG-1:0][BUS_W-1:0] ch_words;
  logic [NUM_CH-1:0][NREG-1:0]            ch_pend;

  assign slot       = addr_i[5:4];
  assign reg_idx    = addr_i[3:2];
  assign unused_lsb = ^addr_i[1:0];
  assign in_chan    = (addr_i[ADDR_W-1:6] == '0) && (int'(slot) < NUM_CH);
  assign is_stat    = (addr_i[ADDR_W-1:2] == STAT_ADDR[ADDR_W-1:2]);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [NREG-1:0] sel;
    assign sel = (wr_en_i && in_chan && int'(slot) == c)
               ? ({{(NREG-1){1'b0}}, 1'b1} << reg_idx) : '0;

    dpwm_chan #(.PRE_W(PRE_W), .PER_W(PER_W)) i_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_sel_i (sel),
      .wdata_i  (wdata_i),
      .words_o  (ch_words[c]),
      .pend_o   (ch_pend[c]),
      .pwm_o    (pwm_o[c])
    );
  end

  always_comb begin
    rd_word = '0;
    if (is_stat) begin
      for (int c = 0; c < NUM_CH; c++) rd_word[STAT_GROUP_W*c +: NREG] = ch_pend[c];
    end else if (in_chan) begin
      for (int c = 0; c < NUM_CH; c++) if (int'(slot) == c) rd_word = ch_words[c][reg_idx];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_word;
  end
  assign rdata_o = rdata_q;

  a_r12_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && !in_chan && !is_stat |=> rdata_o == '0);
endmodule

// File: tb/test_dpwm_top.sv
`timescale 1ns/1ps
module test_dpwm_top;
  logic        clk = 1'b0, rst_ni = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [6:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [1:0]  pwm;
  int          n_chk = 0, n_err = 0;
  bit          done = 1'b0;

  dpwm_top i_dpwm_top (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .pwm_o(pwm)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a falling edge
  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  function automatic logic exp_out(input int pre, input int per, input int duty, input int phase, input logic inv);
    int len, tick;
    len  = (pre + 1) * (per + 1);
    tick = (phase % len) / (pre + 1);
    return logic'(tick < duty) ^ inv;
  endfunction

  task automatic stop_ch(input int ch);
    wr(7'(ch * 16), 32'h8);
    repeat (3) @(negedge clk);
  endtask

  task automatic setup(input int ch, input int pre, input int per, input int duty, input logic [31:0] ctl);
    wr(7'(ch * 16 + 4), 32'(pre));
    wr(7'(ch * 16 + 8), 32'(per));
    wr(7'(ch * 16 + 12), 32'(duty));
    wr(7'(ch * 16), ctl);
  endtask

  task automatic run_check(input int ch, input int pre, input int per, input int duty,
                           input logic inv, input int n, input string req);
    int bad = 0;
    logic fa = 1'b0, fe = 1'b0;
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      logic e;
      @(negedge clk);
      e = exp_out(pre, per, duty, i, inv);
      if (pwm[ch] !== e) begin
        if (bad == 0) begin fa = pwm[ch]; fe = e; end
        bad++;
      end
    end
    chk(bad == 0, req, 32'(fa), 32'(fe));
  endtask

  // ctrl write injected at phase 2; output must follow the waveform until last_live
  task automatic stop_test(input logic [31:0] ctl_word, input int last_live, input string req);
    int bad = 0;
    logic fa = 1'b0, fe = 1'b0;
    setup(0, 1, 4, 3, 32'h1);
    @(negedge clk);
    for (int i = 0; i < 30; i++) begin
      logic e;
      @(negedge clk);
      e = (i < last_live) ? exp_out(1, 4, 3, i, 1'b0) : 1'b0;
      if (pwm[0] !== e) begin
        if (bad == 0) begin fa = pwm[0]; fe = e; end
        bad++;
      end
      if (i == 2) begin wr_en = 1'b1; addr = 7'h00; wdata = ctl_word; end
      if (i == 3) wr_en = 1'b0;
    end
    chk(bad == 0, req, 32'(fa), 32'(fe));
    stop_ch(0);
  endtask

  initial begin
    logic [31:0] d;
    int seed;
    seed = int'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    chk(pwm == 2'b00, "R1 outputs after reset", 32'(pwm), 0);
    rd(7'h40, d); chk(d == 0, "R1 status after reset", d, 0);
    rd(7'h00, d); chk(d == 0, "R1 control after reset", d, 0);

    wr(7'h18, 32'hFFFF_FFFF); rd(7'h18, d); chk(d == 32'hFFF, "R2 ch1 length masked", d, 32'hFFF);
    wr(7'h04, 32'hFFFF_FFFF); rd(7'h04, d); chk(d == 32'h3FF, "R2 ch0 divider masked", d, 32'h3FF);
    wr(7'h03, 32'hFFFF_FFF6); rd(7'h00, d); chk(d == 32'h36, "R2 ch0 control masked, low addr bits ignored", d, 32'h36);

    wr(7'h00, 32'h0);
    rd(7'h40, d); chk(d == 32'h1, "R4 control flag right after write", d, 32'h1);
    rd(7'h40, d); chk(d == 32'h0, "R4 control flag cleared", d, 32'h0);

    wr(7'h14, 32'h3);
    rd(7'h40, d); chk(d == 32'h200, "R3 R9 ch1 divider flag at bit 9", d, 32'h200);
    rd(7'h40, d); chk(d == 32'h0, "R9 idle transfer done", d, 32'h0);

    setup(0, 1, 4, 3, 32'h1); run_check(0, 1, 4, 3, 1'b0, 25, "R5 basic waveform"); stop_ch(0);
    setup(0, 0, 5, 0, 32'h1); run_check(0, 0, 5, 0, 1'b0, 14, "R5 high time zero"); stop_ch(0);
    setup(0, 2, 3, 9, 32'h1); run_check(0, 2, 3, 9, 1'b0, 30, "R5 high time above length"); stop_ch(0);
    setup(1, 1, 3, 2, 32'h3); run_check(1, 1, 3, 2, 1'b1, 20, "R6 inverted waveform"); stop_ch(1);
    wr(7'h10, 32'h2); repeat (2) @(negedge clk);
    chk(pwm[1] == 1'b1, "R6 stopped level follows invert", 32'(pwm[1]), 1);
    wr(7'h10, 32'h0); repeat (2) @(negedge clk);

    for (int k = 0; k < 8; k++) begin
      int ch, pre, per, duty;
      logic inv;
      ch   = int'($urandom % 2);
      pre  = int'($urandom % 4);
      per  = int'($urandom % 16);
      duty = int'($urandom % 18);
      inv  = logic'($urandom % 2);
      setup(ch, pre, per, duty, inv ? 32'h3 : 32'h1);
      run_check(ch, pre, per, duty, inv, 2 * (pre + 1) * (per + 1) + 3, "R5 R6 random waveform");
      stop_ch(ch);
    end

    begin
      int bad = 0;
      setup(0, 1, 4, 2, 32'h5);
      run_check(0, 1, 4, 2, 1'b0, 10, "R7 first cycle");
      repeat (2) @(negedge clk);
      wr(7'h0C, 32'h5);
      rd(7'h40, d); chk(d == 32'h8, "R7 high time pending mid cycle", d, 32'h8);
      for (int i = 0; i < 16; i++) begin
        @(negedge clk);
        if (pwm[0] !== logic'(i >= 6)) bad++;
      end
      chk(bad == 0, "R7 new high time starts at boundary", 32'(bad), 0);
      rd(7'h40, d); chk(d == 32'h0, "R7 flag cleared after boundary", d, 32'h0);
      stop_ch(0);
    end

    setup(0, 0, 7, 4, 32'h1);
    run_check(0, 0, 7, 4, 1'b0, 8, "R8 base waveform");
    wr(7'h08, 32'h3);
    rd(7'h40, d); chk(d == 32'h4, "R8 length pending", d, 32'h4);
    repeat (5) @(negedge clk);
    rd(7'h40, d); chk(d == 32'h4, "R8 length waits for load bit", d, 32'h4);
    wr(7'h0C, 32'h1);
    rd(7'h40, d); chk(d == 32'hC, "R8 high time flag set", d, 32'hC);
    rd(7'h40, d); chk(d == 32'h4, "R8 high time lands next clock", d, 32'h4);
    wr(7'h00, 32'h21);
    rd(7'h40, d); chk(d == 32'h5, "R8 load-length control pending", d, 32'h5);
    rd(7'h40, d); chk(d == 32'h4, "R8 length one clock later", d, 32'h4);
    rd(7'h40, d); chk(d == 32'h0, "R8 length transferred", d, 32'h0);
    wr(7'h04, 32'h2);
    repeat (3) @(negedge clk);
    rd(7'h40, d); chk(d == 32'h2, "R8 divider waits for load bit", d, 32'h2);
    wr(7'h00, 32'h11);
    rd(7'h40, d); chk(d == 32'h3, "R8 load-divider control pending", d, 32'h3);
    rd(7'h40, d); chk(d == 32'h2, "R8 divider one clock later", d, 32'h2);
    rd(7'h40, d); chk(d == 32'h0, "R8 divider transferred", d, 32'h0);
    stop_ch(0);

    stop_test(32'h0, 10, "R10 cycle completes before stop");
    stop_test(32'h8, 5, "R11 stop now");

    wr(7'h20, 32'h1); wr(7'h2C, 32'h5); wr(7'h40, 32'hF);
    rd(7'h20, d); chk(d == 0, "R12 slot 2 control reads zero", d, 0);
    rd(7'h2C, d); chk(d == 0, "R12 slot 2 high time reads zero", d, 0);
    rd(7'h44, d); chk(d == 0, "R12 0x44 reads zero", d, 0);
    rd(7'h60, d); chk(d == 0, "R12 0x60 reads zero", d, 0);
    rd(7'h40, d); chk(d == 0, "R12 status unchanged by writes", d, 0);
    rd(7'h00, d); chk(d == 32'h8, "R12 no alias into ch0 control", d, 32'h8);
    chk(pwm == 2'b00, "R12 outputs unchanged", 32'(pwm), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog (all requirements): actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule